// File: doc/BRIEF.md
# Oscillator Trim Binary-Search Calibrator

This block finds the 5-bit trim setting that brings a slow on-chip oscillator, nominally 32 kHz, as near as possible to its target rate. It drives the trim code and asks an external frequency meter for a count. The meter reports how many cycles of a fast reference fall into one window of the slow clock. The block then narrows its search interval and repeats until a count lands in the accepted band or the interval cannot be narrowed any further.

A pulse on the start input begins a calibration. The block applies a candidate code and holds it while a measurement is pending. It raises a measure request and waits for an acknowledge that carries the 16-bit count. A request that receives no acknowledge within a fixed number of microsecond ticks is abandoned, and its count is taken as zero. When the search ends, the chosen code stays on the trim output and a one-cycle done pulse marks it as valid.

If no candidate lands in the band, the two codes left at the ends of the interval are measured again. The block keeps the one whose count lies nearer the lower edge of the band.

Top module: `osc_trim_cal`

## Requirements
- R1: While reset is held and after its release, done_o and meas_req_o are 0 and trim_o is 0.
- R2: A calibration starts with the interval [0, 31]. Each candidate is floor((left+right)/2). The meter count rises with the trim code. A count above 796 sets right to the candidate. Any other count outside the band sets left to the candidate.
- R3: A count from 792 to 796 inclusive ends the search at once, and the candidate becomes the result.
- R4: When the candidate equals left, the search stops without measuring that candidate. The block then measures the left code, then the right code.
- R5: Of the two endpoints, the block picks the one whose unsigned distance |count - 792| is strictly smaller. On equal distances it picks the right code. The distances never wrap.
- R6: A request that receives no acknowledge within 8000 us_tick_i pulses is dropped after exactly that many ticks, and its count is taken as 0.
- R7: trim_o takes its new value at least one cycle before meas_req_o rises. It keeps that value until the request ends. meas_req_o stays high until meas_ack_i or the timeout.
- R8: done_o is high for exactly one cycle at the end of each calibration. trim_o then holds the result until the next start.
- R9: A start pulse during a calibration is ignored. The search sequence and the result are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a calibration (ignored while busy) |
| us_tick_i | input | 1 | One-cycle pulse every microsecond, used for the timeout |
| meas_ack_i | input | 1 | Meter result valid, one cycle |
| meas_cnt_i | input | 16 | Meter count, sampled with meas_ack_i |
| meas_req_o | output | 1 | Measurement request, held until acknowledge or timeout |
| trim_o | output | 5 | Trim code applied to the oscillator |
| done_o | output | 1 | One-cycle pulse: trim_o is the calibration result |

## Verification
The bench drives a linear meter model through searches that exercise specific boundaries. One search hits exactly 792 and another exactly 796; a design with an exclusive band would keep searching and return a different code. One meter just misses the band at 791 and at 797; a design with an inclusive-by-one error would stop too early. In one endpoint case the lower-edge rule picks the left code while a rule measured from the band centre would pick the right code. In another case the two distances are equal, which catches a design that prefers left on a tie. A meter that never answers shows whether the request is dropped after exactly 8000 ticks and the count taken as zero. A start pulse in the middle of a run shows whether the search restarts.

// File: rtl/otc_pkg.sv
// Shared types for the oscillator trim calibrator.
// Assumes: nothing beyond IEEE 1800-2017.
package otc_pkg;

    // Controller states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_APPLY,
        ST_MEAS,
        ST_EVAL,
        ST_DONE
    } otc_state_e;

    // What the measurement in flight is for.
    typedef enum logic [1:0] {
        PH_MID,
        PH_LEFT,
        PH_RIGHT
    } otc_phase_e;

endpackage

// File: rtl/otc_timeout.sv
// Measurement timeout: counts us ticks while enabled and flags the tick that
// completes LIMIT of them.
// Assumes: en drops the cycle after hit, which clears the count.
module otc_timeout #(
    parameter int LIMIT = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Count ticks during a pending request, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = en && tick && (cnt_q == LAST);

endmodule

// File: rtl/otc_judge.sv
// Count evaluation: band test, above-band test and endpoint choice by
// distance to the lower band edge (tie goes to the right endpoint).
// Assumes: unsigned counts; distances are computed without wraparound.
module otc_judge #(
    parameter int CNT_W  = 16,
    parameter int TARGET = 794,
    parameter int TOL    = 2
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cnt_left,
    input  logic [CNT_W-1:0] cnt_right,
    output logic             in_band,
    output logic             above,
    output logic             pick_right
);
    localparam logic [CNT_W-1:0] LO = CNT_W'(TARGET - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(TARGET + TOL);

    // Unsigned distance to the lower band edge.
    function automatic logic [CNT_W-1:0] dist_lo(input logic [CNT_W-1:0] v);
        return (v >= LO) ? (v - LO) : (LO - v);
    endfunction

    logic [CNT_W-1:0] d_left;
    logic [CNT_W-1:0] d_right;

    // Classify the latest count and compare the endpoint distances.
    always_comb begin
        in_band    = (cnt >= LO) && (cnt <= HI);
        above      = (cnt > HI);
        d_left     = dist_lo(cnt_left);
        d_right    = dist_lo(cnt_right);
        pick_right = !(d_left < d_right);
    end

endmodule

// File: rtl/osc_trim_cal.sv
// Binary-search trim calibrator. It applies a code, waits a settle cycle,
// requests a meter count, and narrows a closed [left,right] interval. It stops
// on an in-band count, or when the midpoint equals left, in which case it
// re-measures both endpoints and keeps the better one.
// Assumes: the meter count grows with the trim code; meas_ack_i is one cycle.
module osc_trim_cal #(
    parameter int CODE_W     = 5,
    parameter int CNT_W      = 16,
    parameter int TARGET     = 794,
    parameter int TOL        = 2,
    parameter int TIMEOUT_US = 8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              us_tick_i,
    input  logic              meas_ack_i,
    input  logic [CNT_W-1:0]  meas_cnt_i,
    output logic              meas_req_o,
    output logic [CODE_W-1:0] trim_o,
    output logic              done_o
);
    import otc_pkg::*;

    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    otc_state_e        state_q;
    otc_phase_e        phase_q;
    logic [CODE_W-1:0] left_q;
    logic [CODE_W-1:0] right_q;
    logic [CODE_W-1:0] trim_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_left_q;
    logic [CODE_W:0]   sum_w;
    logic [CODE_W-1:0] mid_w;
    logic              tmo_hit;
    logic              in_band;
    logic              above;
    logic              pick_right;
    logic              busy;

    // Floor midpoint of the current interval.
    always_comb begin
        sum_w = {1'b0, left_q} + {1'b0, right_q};
        mid_w = sum_w[CODE_W:1];
    end

    otc_timeout #(.LIMIT(TIMEOUT_US)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q == ST_MEAS),
        .tick  (us_tick_i),
        .hit   (tmo_hit)
    );

    otc_judge #(.CNT_W(CNT_W), .TARGET(TARGET), .TOL(TOL)) u_judge (
        .cnt        (cnt_q),
        .cnt_left   (cnt_left_q),
        .cnt_right  (cnt_q),
        .in_band    (in_band),
        .above      (above),
        .pick_right (pick_right)
    );

    // Search controller: interval, applied code and captured counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            phase_q    <= PH_MID;
            left_q     <= '0;
            right_q    <= '0;
            trim_q     <= '0;
            cnt_q      <= '0;
            cnt_left_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        left_q  <= '0;
                        right_q <= CODE_MAX;
                        state_q <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (mid_w == left_q) begin
                        trim_q  <= left_q;
                        phase_q <= PH_LEFT;
                    end else begin
                        trim_q  <= mid_w;
                        phase_q <= PH_MID;
                    end
                    state_q <= ST_APPLY;
                end
                ST_APPLY: begin
                    state_q <= ST_MEAS;
                end
                ST_MEAS: begin
                    if (meas_ack_i) begin
                        cnt_q   <= meas_cnt_i;
                        state_q <= ST_EVAL;
                    end else if (tmo_hit) begin
                        cnt_q   <= '0;
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    case (phase_q)
                        PH_MID: begin
                            if (in_band) begin
                                state_q <= ST_DONE;
                            end else begin
                                if (above) right_q <= trim_q;
                                else       left_q  <= trim_q;
                                state_q <= ST_PICK;
                            end
                        end
                        PH_LEFT: begin
                            cnt_left_q <= cnt_q;
                            trim_q     <= right_q;
                            phase_q    <= PH_RIGHT;
                            state_q    <= ST_APPLY;
                        end
                        default: begin
                            trim_q  <= pick_right ? right_q : left_q;
                            state_q <= ST_DONE;
                        end
                    endcase
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign meas_req_o = (state_q == ST_MEAS);
    assign done_o     = (state_q == ST_DONE);
    assign trim_o     = trim_q;

endmodule

// File: rtl/otc_checker.sv
// Protocol checker for osc_trim_cal, bound to every instance.
// Assumes: tmo and busy are the top's internal timeout and busy signals.
module otc_checker #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              meas_ack_i,
    input logic              meas_req_o,
    input logic [CODE_W-1:0] trim_o,
    input logic              done_o,
    input logic              tmo,
    input logic              busy
);
    // R7: code unchanged in every cycle of a request, including the first
    a_r7_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req_o |-> $stable(trim_o));

    // R7/R6: a request ends only on acknowledge or timeout
    a_r6_req_end_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(meas_req_o) |-> ($past(meas_ack_i) || $past(tmo)));

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: no request in flight when done is signalled
    a_r8_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !meas_req_o);

    // R9: a running calibration is not aborted or restarted
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_o) |=> busy);

    // R8: trim output holds between calibrations
    a_r8_trim_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i && !$past(done_o)) |=> $stable(trim_o));

endmodule

bind osc_trim_cal otc_checker #(.CODE_W(CODE_W)) u_otc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .meas_ack_i (meas_ack_i),
    .meas_req_o (meas_req_o),
    .trim_o     (trim_o),
    .done_o     (done_o),
    .tmo        (tmo_hit),
    .busy       (busy)
);

// File: tb/osc_trim_cal_bench.sv
module osc_trim_cal_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        us_tick_i = 1'b1;
    logic        meas_ack_i = 1'b0;
    logic [15:0] meas_cnt_i = '0;
    logic        meas_req_o;
    logic [4:0]  trim_o;
    logic        done_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    int n_meas   = 0;
    int lat_cnt  = 0;
    bit meter_on = 1'b1;
    int m_base   = 0;
    int m_step   = 0;

    always #5 clk = ~clk;

    osc_trim_cal u_osc_trim_cal (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .us_tick_i  (us_tick_i),
        .meas_ack_i (meas_ack_i),
        .meas_cnt_i (meas_cnt_i),
        .meas_req_o (meas_req_o),
        .trim_o     (trim_o),
        .done_o     (done_o)
    );

    // Vectors: meter base, meter step per code, expected code, expected measurements.
    localparam int NV = 7;
    localparam int VEC [NV][4] = '{
        '{734, 4,  15, 1},  // R3: middle hits 794 at once
        '{700, 4,  23, 2},  // R2 R3: lower edge 792 accepted
        '{736, 4,  15, 1},  // R3: upper edge 796 accepted
        '{731, 4,  16, 5},  // R3: 791 rejected, 795 accepted
        '{617, 9,  19, 7},  // R4 R5: 788 vs 797, lower-edge rule picks left
        '{900, 10, 0,  6},  // R4 R5: left strictly closer, down to code 0
        '{0,   0,  31, 7}   // R5: tie, right chosen
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Meter model: answers each request after two cycles with base + step*code.
    initial begin
        forever begin
            @(negedge clk);
            if (meas_ack_i) begin
                meas_ack_i = 1'b0;
            end else if (meas_req_o && meter_on) begin
                if (lat_cnt == 2) begin
                    meas_ack_i = 1'b1;
                    meas_cnt_i = 16'(m_base + m_step * int'(trim_o));
                    n_meas++;
                    lat_cnt = 0;
                end else begin
                    lat_cnt++;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_fails++;
                n_checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
                $finish;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Wait for done; return the code; check the done pulse width and hold (R8).
    task automatic wait_done(output int code);
        while (!done_o) @(negedge clk);
        code = int'(trim_o);
        @(negedge clk);
        check(!done_o, "R8 done width", int'(done_o), 0);
        check(int'(trim_o) == code, "R8 code hold", int'(trim_o), code);
    endtask

    initial begin
        int code;
        int hi_cycles;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!done_o, "R1 done", int'(done_o), 0);
        check(!meas_req_o, "R1 req", int'(meas_req_o), 0);
        check(trim_o == 5'd0, "R1 trim", int'(trim_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!meas_req_o && !done_o && trim_o == 5'd0, "R1 after release", int'(trim_o), 0);

        // Vector table walk: R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            m_base = VEC[i][0];
            m_step = VEC[i][1];
            n_meas = 0;
            pulse_start();
            wait_done(code);
            check(code == VEC[i][2], "R2 R3 R4 R5 result code", code, VEC[i][2]);
            check(n_meas == VEC[i][3], "R2 R4 measurement count", n_meas, VEC[i][3]);
        end

        // R9: extra start pulses mid-run are ignored
        m_base = 617;
        m_step = 9;
        n_meas = 0;
        pulse_start();
        repeat (6) @(negedge clk);
        pulse_start();
        repeat (9) @(negedge clk);
        pulse_start();
        wait_done(code);
        check(code == 19, "R9 result with restarts", code, 19);
        check(n_meas == 7, "R9 measurement count", n_meas, 7);

        // R6: meter silent; each request drops after 8000 ticks, count taken as 0
        meter_on = 1'b0;
        pulse_start();
        while (!meas_req_o) @(negedge clk);
        hi_cycles = 0;
        while (meas_req_o) begin
            hi_cycles++;
            @(negedge clk);
        end
        check(hi_cycles == 8000, "R6 request length in ticks", hi_cycles, 8000);
        check(trim_o == 5'd15, "R7 first candidate", int'(trim_o), 15);
        wait_done(code);
        check(code == 31, "R6 timeout result", code, 31);
        meter_on = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule